// File: doc/BRIEF.md
# Lag-Domain Cross-Correlator with Integer Delay Alignment

This block correlates two few-bit sampled signal streams, X and Y, in the time-lag domain. The Y stream first passes through a memory-based integer delay. This aligns the two streams to within half a sample. For each of a fixed set of lags, the block then multiplies the current X sample by a Y sample from that many samples earlier. Each lag keeps its own running sum of these products over a programmable number of accepted samples.

When an integration finishes, every lag sum is moved into an output buffer in the same cycle that the sums restart from zero. The buffer is then streamed out one lag per clock. The spectrum is formed later by a Fourier transform outside this block.

Two arithmetic modes are offered. The first uses signed 4-bit samples with full multipliers. The second uses only the sign bit of each sample, with an exclusive-OR standing in for the multiplier. The delay, mode and length are sampled once per integration, so every integration uses a single, consistent setup.

Top module: `lag_correlator`

## Requirements
- R1: In wide mode (`bit_mode`=0), lag k adds the signed product X[n]·Y'[n−k] for every accepted sample n of the integration. Here samples are 4-bit two's complement and Y' is the delayed Y stream.
- R2: In sign mode (`bit_mode`=1), only bit 3 of each sample is used. If the exclusive-OR of the two sign bits is 0, the lag adds +1. If it is 1, the lag adds −1.
- R3: Y'[n] = Y[n−d], where d is the delay setting in the range 0..63. Y samples from before the most recent reset count as 0, which has sign bit 0.
- R4: Delay, mode and length are taken from the inputs only on the first accepted sample of an integration. Changing them later in that integration has no effect on its results.
- R5: Cycles with `in_valid` low change no sum and do not advance the integration. The sample values on those cycles are ignored.
- R6: An integration ends after `int_len` accepted samples (`int_len` between 1 and 2^20). All sums clear at that point. The very next accepted sample opens a new integration, so no sample is lost between integrations.
- R7: Readout starts on the clock after the closing sample is accepted. Exactly one lag is presented per cycle, in the order 0 to 15, with `out_valid` high and `out_lag` giving the index. `out_last` is high only with lag 15.
- R8: After reset, `out_valid` and `out_last` are low, every sum is zero and the delay memory holds zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample pair present this cycle |
| x_smp | input | 4 | X sample, two's complement |
| y_smp | input | 4 | Y sample, two's complement |
| bit_mode | input | 1 | 1 selects sign-only arithmetic |
| dly_set | input | 6 | Integer delay applied to Y, in samples |
| int_len | input | 21 | Accepted samples per integration |
| out_valid | output | 1 | Readout word present |
| out_last | output | 1 | Final lag of the readout |
| out_lag | output | 4 | Lag index of the readout word |
| out_value | output | 32 | Signed lag sum |

## Verification
The assertions assume that `int_len` is at least the number of lags. With that assumption, a readout always finishes before the next integration closes and never has its buffer replaced partway through. They also assume that `int_len` is non-zero while an integration is being opened.

The stimulus only ever uses lengths of 32 or more samples. Its idle cycles and its mid-integration changes to delay, mode and length exercise the hold properties without breaking these assumptions.

// File: rtl/lag_correlator.sv
module lag_correlator #(
  parameter int NLAGS  = 16,
  parameter int SW     = 4,
  parameter int MAXDLY = 63,
  parameter int ACCW   = 32,
  parameter int MAXLEN = 1 << 20
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [SW-1:0]                 x_smp,
  input  logic [SW-1:0]                 y_smp,
  input  logic                          bit_mode,
  input  logic [$clog2(MAXDLY+1)-1:0]   dly_set,
  input  logic [$clog2(MAXLEN+1)-1:0]   int_len,
  output logic                          out_valid,
  output logic                          out_last,
  output logic [$clog2(NLAGS)-1:0]      out_lag,
  output logic signed [ACCW-1:0]        out_value
);
  localparam int DW    = $clog2(MAXDLY + 1);
  localparam int LENW  = $clog2(MAXLEN + 1);
  localparam int LW    = $clog2(NLAGS);
  localparam int AW    = $clog2(MAXDLY + NLAGS);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = 2 * SW;

  logic [SW-1:0]          mem [DEPTH];
  logic [AW-1:0]          wp;
  logic [LENW-1:0]        cnt, len_act;
  logic [DW-1:0]          dly_act;
  logic                   mode_act;
  logic signed [ACCW-1:0] acc  [NLAGS];
  logic signed [ACCW-1:0] obuf [NLAGS];
  logic signed [PW-1:0]   prod [NLAGS];
  logic                   rd_busy;
  logic [LW-1:0]          rd_idx;

  wire             opening  = (cnt == '0);
  wire [DW-1:0]    dly_use  = opening ? dly_set  : dly_act;
  wire [LENW-1:0]  len_use  = opening ? int_len  : len_act;
  wire             mode_use = opening ? bit_mode : mode_act;
  wire             dump     = in_valid && (cnt == len_use - LENW'(1));

  for (genvar k = 0; k < NLAGS; k++) begin : g_lag
    wire [AW:0]     off = (AW+1)'(dly_use) + (AW+1)'(k);
    wire [SW-1:0]   tap = (off == '0) ? y_smp : mem[wp - off[AW-1:0]];
    wire            neg = x_smp[SW-1] ^ tap[SW-1];
    assign prod[k] = mode_use ? (neg ? -PW'(1) : PW'(1))
                              : PW'($signed(x_smp) * $signed(tap));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (in_valid) begin
      mem[wp] <= y_smp;
      wp      <= wp + AW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      len_act  <= '0;
      dly_act  <= '0;
      mode_act <= 1'b0;
    end else if (in_valid) begin
      if (opening) begin
        len_act  <= int_len;
        dly_act  <= dly_set;
        mode_act <= bit_mode;
      end
      cnt <= dump ? '0 : cnt + LENW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NLAGS; i++) begin
        acc[i]  <= '0;
        obuf[i] <= '0;
      end
    end else if (in_valid) begin
      for (int i = 0; i < NLAGS; i++) begin
        if (dump) begin
          obuf[i] <= acc[i] + {{(ACCW-PW){prod[i][PW-1]}}, prod[i]};
          acc[i]  <= '0;
        end else begin
          acc[i]  <= acc[i] + {{(ACCW-PW){prod[i][PW-1]}}, prod[i]};
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_busy <= 1'b0;
      rd_idx  <= '0;
    end else if (dump) begin
      rd_busy <= 1'b1;
      rd_idx  <= '0;
    end else if (rd_busy) begin
      rd_busy <= (rd_idx != LW'(NLAGS - 1));
      rd_idx  <= rd_idx + LW'(1);
    end
  end

  assign out_valid = rd_busy;
  assign out_last  = rd_busy && (rd_idx == LW'(NLAGS - 1));
  assign out_lag   = rd_idx;
  assign out_value = obuf[rd_idx];

  a_r7_last_final: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> (out_valid && out_lag == LW'(NLAGS - 1)));

  a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last && !dump) |=> (out_valid && out_lag == $past(out_lag) + LW'(1)));

  a_r7_start: assert property (@(posedge clk) disable iff (!rst_n)
    dump |=> (out_valid && out_lag == '0));

  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(cnt));

  a_r4_setup_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |=> ($stable(dly_act) && $stable(mode_act) && $stable(len_act)));

  a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
    dump |=> (cnt == '0));

  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> (cnt < len_act));

  a_r8_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !out_last));
endmodule

// File: tb/test_lag_correlator.sv
module test_lag_correlator;
  localparam int NL = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [3:0] x_smp = '0, y_smp = '0;
  logic bit_mode = 1'b0;
  logic [5:0] dly_set = '0;
  logic [20:0] int_len = 21'd32;
  logic out_valid, out_last;
  logic [3:0] out_lag;
  logic signed [31:0] out_value;

  int checks = 0, errors = 0;
  logic [3:0] hx [0:1023];
  logic [3:0] hy [0:1023];
  int ns = 0;
  int expv [0:NL-1];

  always #5 clk = ~clk;

  lag_correlator i_lag_correlator (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .x_smp(x_smp), .y_smp(y_smp),
    .bit_mode(bit_mode), .dly_set(dly_set), .int_len(int_len),
    .out_valid(out_valid), .out_last(out_last), .out_lag(out_lag), .out_value(out_value));

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ns = 0;
  endtask

  task automatic push(logic [3:0] x, logic [3:0] y);
    @(negedge clk);
    x_smp = x; y_smp = y; in_valid = 1'b1;
    hx[ns] = x; hy[ns] = y; ns++;
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    in_valid = 1'b0;
    x_smp = 4'($urandom); y_smp = 4'($urandom);
  endtask

  task automatic calc(int start, int len, int d, bit m);
    for (int k = 0; k < NL; k++) begin
      int s = 0;
      for (int n = start; n < start + len; n++) begin
        int j = n - d - k;
        logic [3:0] yv = (j < 0) ? 4'd0 : hy[j];
        if (m) s += (hx[n][3] ^ yv[3]) ? -1 : 1;
        else   s += $signed(hx[n]) * $signed(yv);
      end
      expv[k] = s;
    end
  endtask

  task automatic collect(string req, bit drop);
    for (int k = 0; k < NL; k++) begin
      @(negedge clk);
      if (drop) in_valid = 1'b0;
      chk(out_valid && out_lag == 4'(k), {req, " readout order"}, out_lag, k);
      chk(out_value == expv[k], {req, " lag value"}, out_value, expv[k]);
      chk(out_last == (k == NL - 1), "R7 last flag", out_last, k == NL - 1);
    end
    if (drop) begin
      @(negedge clk);
      chk(!out_valid, "R7 readout ends", out_valid, 0);
    end
  endtask

  task automatic run_int(int len, int d, bit m, bit gaps, bit perturb, string req);
    int start = ns;
    dly_set = 6'(d); bit_mode = m; int_len = 21'(len);
    for (int i = 0; i < len; i++) begin
      if (gaps && (i % 3 == 1)) idle_cycle();
      push(4'($urandom), 4'($urandom));
      if (perturb && i == 1) begin
        dly_set = 6'(d ^ 11); bit_mode = ~m; int_len = 21'd5;
      end
    end
    calc(start, len, d, m);
    collect(req, 1'b1);
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk(!out_valid, "R8 valid after reset", out_valid, 0);
    chk(!out_last, "R8 last after reset", out_last, 0);
  endtask

  task automatic t_wide();
    do_reset();
    run_int(40, 0, 1'b0, 1'b0, 1'b0, "R1");
  endtask

  task automatic t_delay();
    do_reset();
    run_int(64, 5, 1'b0, 1'b0, 1'b0, "R3");
  endtask

  task automatic t_sign();
    do_reset();
    run_int(50, 3, 1'b1, 1'b0, 1'b0, "R2");
  endtask

  task automatic t_gaps();
    do_reset();
    run_int(45, 2, 1'b0, 1'b1, 1'b0, "R5");
  endtask

  task automatic t_change();
    do_reset();
    run_int(48, 9, 1'b0, 1'b0, 1'b1, "R4");
  endtask

  task automatic t_maxdelay();
    do_reset();
    run_int(100, 63, 1'b0, 1'b0, 1'b0, "R3 max delay");
  endtask

  task automatic t_extreme();
    int start;
    do_reset();
    start = ns;
    dly_set = 6'd0; bit_mode = 1'b0; int_len = 21'd32;
    for (int i = 0; i < 32; i++) push(4'h8, 4'h8);
    calc(start, 32, 0, 1'b0);
    chk(expv[0] == 64 * 32, "R1 extreme model", expv[0], 64 * 32);
    collect("R1 extreme", 1'b1);
  endtask

  task automatic t_back2back();
    int sa, sb;
    do_reset();
    sa = ns;
    dly_set = 6'd4; bit_mode = 1'b0; int_len = 21'd32;
    for (int i = 0; i < 32; i++) push(4'($urandom), 4'($urandom));
    calc(sa, 32, 4, 1'b0);
    sb = ns;
    dly_set = 6'd7; bit_mode = 1'b1; int_len = 21'd40;
    fork
      for (int i = 0; i < 40; i++) push(4'($urandom), 4'($urandom));
      collect("R6 first", 1'b0);
    join
    calc(sb, 40, 7, 1'b1);
    collect("R6 second", 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_wide();
    t_delay();
    t_sign();
    t_gaps();
    t_change();
    t_maxdelay();
    t_extreme();
    t_back2back();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule